// File: doc/BRIEF.md
# SIMD Saturating Pack Unit

This block narrows two packed vector operands into one result vector. Each source element is read as a signed two's-complement integer. It is clamped to the range of an element half its width, and the low bits are kept. Four narrowing modes are supported: 16-bit elements to unsigned or signed bytes, and 32-bit elements to unsigned or signed halfwords.

The unit works on 128-bit or 256-bit operands. In the 256-bit width, each operand is treated as two independent 128-bit lanes, and each lane is packed separately. The packed result and its valid flag are registered one clock after an accepted input. A vector execution pipeline uses it as a single-cycle stage.

Top module: `simd_sat_pack`

## Requirements
- R1: Every source element is interpreted as signed two's-complement in all four modes, including the unsigned ones. A 16-bit source of 0x8000 is therefore below zero.
- R2: With `mode` = 2'b00, each 16-bit source element becomes an 8-bit result clamped to 0..255.
- R3: With `mode` = 2'b01, each 16-bit source element becomes an 8-bit result clamped to -128..127.
- R4: With `mode` = 2'b10, each 32-bit source element becomes a 16-bit result clamped to 0..65535.
- R5: With `mode` = 2'b11, each 32-bit source element becomes a 16-bit result clamped to -32768..32767.
- R6: With `wide` = 0, the layout is as follows:
  - Source element i of A sits at bits [i*S +: S] of `op_a`, where S is the source element width. Its result goes to bits [i*D +: D], where D = S/2.
  - The results from B follow directly above, starting at bit 64.
  - Result bits 255:128 are zero.
  - Operand bits 255:128 have no effect on the result.
- R7: With `wide` = 1, the result is built in 64-bit quarters, from low to high:
  - A's lower 128 bits, packed;
  - B's lower 128 bits, packed;
  - A's upper 128 bits, packed;
  - B's upper 128 bits, packed.
- R8: `out_valid` is high in the cycle after a clock edge that sampled `in_valid` high, and low after an edge that sampled it low. `out_res` carries that input's result in the same cycle.
- R9: When `in_valid` is low, `out_res` keeps its previous value whatever the other inputs do.
- R10: A synchronous active-high `rst` clears `out_valid` and `out_res` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Accepts the operands this cycle |
| op_a | input | 256 | First packed operand |
| op_b | input | 256 | Second packed operand |
| mode | input | 2 | Narrowing mode: 00 u8, 01 s8, 10 u16, 11 s16 |
| wide | input | 1 | 0 = 128-bit, 1 = 256-bit |
| out_valid | output | 1 | Result valid |
| out_res | output | 256 | Packed saturated result |

## Verification
The hardest cases sit where a source element lies exactly on a clamp edge or one step past it, in a lane and position that must land in the right quarter. Random operands almost never produce these values.

The bench therefore holds a table of edge values for each source width:
- the most negative and most positive sources;
- each limit;
- each limit's neighbours.

It rotates this table through every element slot of both operands, in every mode and both widths. Upper operand bits stay populated in the 128-bit width, so any leak of those bits into the result shows.

// File: rtl/simd_pack_pkg.sv
package simd_pack_pkg;

    typedef enum logic [1:0] {
        PK_U8  = 2'b00,
        PK_S8  = 2'b01,
        PK_U16 = 2'b10,
        PK_S16 = 2'b11
    } pack_mode_e;

    // bit 0 of the mode selects signed clamping, bit 1 selects 32-bit sources
    function automatic logic mode_is_signed(input logic [1:0] m);
        return m[0];
    endfunction

    function automatic logic mode_is_wide_src(input logic [1:0] m);
        return m[1];
    endfunction

endpackage

// File: rtl/sat_narrow.sv
module sat_narrow #(
    parameter int SRC_W = 16
) (
    input  logic signed [SRC_W-1:0]   src_i,
    input  logic                      signed_i,
    output logic        [SRC_W/2-1:0] dst_o
);
    localparam int DST_W = SRC_W / 2;

    localparam logic signed [SRC_W-1:0] S_MAX = {{(SRC_W-DST_W+1){1'b0}}, {(DST_W-1){1'b1}}};
    localparam logic signed [SRC_W-1:0] S_MIN = {{(SRC_W-DST_W+1){1'b1}}, {(DST_W-1){1'b0}}};
    localparam logic signed [SRC_W-1:0] U_MAX = {{(SRC_W-DST_W){1'b0}}, {DST_W{1'b1}}};
    localparam logic signed [SRC_W-1:0] U_MIN = '0;

    logic signed [SRC_W-1:0] hi_lim;
    logic signed [SRC_W-1:0] lo_lim;

    always_comb begin
        hi_lim = signed_i ? S_MAX : U_MAX;
        lo_lim = signed_i ? S_MIN : U_MIN;
        if (src_i > hi_lim) begin
            dst_o = hi_lim[DST_W-1:0];
        end else if (src_i < lo_lim) begin
            dst_o = lo_lim[DST_W-1:0];
        end else begin
            dst_o = src_i[DST_W-1:0];
        end
    end

endmodule

// File: rtl/pack_half.sv
module pack_half
    import simd_pack_pkg::*;
#(
    parameter int HALF_W = 128
) (
    input  logic [HALF_W-1:0] a_i,
    input  logic [HALF_W-1:0] b_i,
    input  logic [1:0]        mode_i,
    output logic [HALF_W-1:0] res_o
);
    localparam int N_BYTE = HALF_W / 16;
    localparam int N_HALF = HALF_W / 32;
    localparam int SPLIT  = HALF_W / 2;

    logic [HALF_W-1:0] res_byte;
    logic [HALF_W-1:0] res_hw;
    logic              sgn;

    assign sgn = mode_is_signed(mode_i);

    for (genvar i = 0; i < N_BYTE; i++) begin : g_byte
        sat_narrow #(.SRC_W(16)) i_sat_a (
            .src_i    (a_i[i*16 +: 16]),
            .signed_i (sgn),
            .dst_o    (res_byte[i*8 +: 8])
        );
        sat_narrow #(.SRC_W(16)) i_sat_b (
            .src_i    (b_i[i*16 +: 16]),
            .signed_i (sgn),
            .dst_o    (res_byte[SPLIT + i*8 +: 8])
        );
    end

    for (genvar i = 0; i < N_HALF; i++) begin : g_hw
        sat_narrow #(.SRC_W(32)) i_sat_a (
            .src_i    (a_i[i*32 +: 32]),
            .signed_i (sgn),
            .dst_o    (res_hw[i*16 +: 16])
        );
        sat_narrow #(.SRC_W(32)) i_sat_b (
            .src_i    (b_i[i*32 +: 32]),
            .signed_i (sgn),
            .dst_o    (res_hw[SPLIT + i*16 +: 16])
        );
    end

    assign res_o = mode_is_wide_src(mode_i) ? res_hw : res_byte;

endmodule

// File: rtl/simd_sat_pack.sv
module simd_sat_pack #(
    parameter int HALF_W = 128,
    parameter int HALVES = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    input  logic [HALF_W*HALVES-1:0] op_a,
    input  logic [HALF_W*HALVES-1:0] op_b,
    input  logic [1:0]               mode,
    input  logic                     wide,
    output logic                     out_valid,
    output logic [HALF_W*HALVES-1:0] out_res
);
    localparam int OP_W = HALF_W * HALVES;

    typedef struct packed {
        logic            vld;
        logic [OP_W-1:0] res;
    } pack_state_t;

    pack_state_t st_d, st_q;
    logic [OP_W-1:0] packed_w;

    for (genvar h = 0; h < HALVES; h++) begin : g_half
        logic [HALF_W-1:0] half_res;

        pack_half #(.HALF_W(HALF_W)) i_half (
            .a_i    (op_a[h*HALF_W +: HALF_W]),
            .b_i    (op_b[h*HALF_W +: HALF_W]),
            .mode_i (mode),
            .res_o  (half_res)
        );

        if (h == 0) begin : g_base
            assign packed_w[HALF_W-1:0] = half_res;
        end else begin : g_ext
            assign packed_w[h*HALF_W +: HALF_W] = wide ? half_res : '0;
        end
    end

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.res = packed_w;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.vld;
    assign out_res   = st_q.res;

endmodule

// File: rtl/simd_sat_pack_chk.sv
module simd_sat_pack_chk #(
    parameter int HALF_W = 128,
    parameter int HALVES = 2
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     in_valid,
    input logic [HALF_W*HALVES-1:0] op_a,
    input logic [HALF_W*HALVES-1:0] op_b,
    input logic [1:0]               mode,
    input logic                     wide,
    input logic                     out_valid,
    input logic [HALF_W*HALVES-1:0] out_res
);
    localparam int OP_W = HALF_W * HALVES;

    assert_reset_clears_R10: assert property (@(posedge clk)
        rst |=> (!out_valid && out_res == '0));

    assert_valid_follows_R8: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    assert_idle_low_R8: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    assert_hold_result_R9: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_res));

    assert_narrow_upper_zero_R6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !wide) |=> out_res[OP_W-1:HALF_W] == '0);

    assert_u8_negative_floor_R2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mode == 2'b00 && op_a[15]) |=> out_res[7:0] == 8'h00);

    assert_s8_negative_floor_R3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mode == 2'b01 && op_a[15] && op_a[14:7] != 8'hFF)
        |=> out_res[7:0] == 8'h80);

    assert_s16_positive_ceiling_R5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mode == 2'b11 && !op_a[31] && op_a[30:15] != 16'h0000)
        |=> out_res[15:0] == 16'h7FFF);

    assert_u16_positive_ceiling_R4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mode == 2'b10 && !op_a[31] && op_a[30:16] != 15'h0000)
        |=> out_res[15:0] == 16'hFFFF);

endmodule

bind simd_sat_pack simd_sat_pack_chk #(.HALF_W(HALF_W), .HALVES(HALVES)) i_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .op_a      (op_a),
    .op_b      (op_b),
    .mode      (mode),
    .wide      (wide),
    .out_valid (out_valid),
    .out_res   (out_res)
);

// File: tb/test_simd_sat_pack.sv
`timescale 1ns/1ps
module test_simd_sat_pack;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [255:0] op_a = '0;
    logic [255:0] op_b = '0;
    logic [1:0]   mode = 2'b00;
    logic         wide = 1'b0;
    logic         out_valid;
    logic [255:0] out_res;

    int checks = 0;
    int errors = 0;
    logic [15:0] edge16 [16];
    logic [31:0] edge32 [16];
    logic [255:0] last_exp;

    always #2.5 clk = ~clk;

    simd_sat_pack i_simd_sat_pack (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .op_a      (op_a),
        .op_b      (op_b),
        .mode      (mode),
        .wide      (wide),
        .out_valid (out_valid),
        .out_res   (out_res)
    );

    function automatic logic [255:0] model(input logic [255:0] a, input logic [255:0] b,
                                           input logic [1:0] m, input logic w);
        logic [255:0] r = '0;
        int  sw = m[1] ? 32 : 16;
        int  dw = sw / 2;
        int  n  = 128 / sw;
        longint hi, lo, v;
        if (m[0]) begin
            hi = (64'sd1 <<< (dw - 1)) - 1;
            lo = -(64'sd1 <<< (dw - 1));
        end else begin
            hi = (64'sd1 <<< dw) - 1;
            lo = 0;
        end
        for (int q = 0; q < 4; q++) begin
            if (!w && q >= 2) continue;
            for (int i = 0; i < n; i++) begin
                int idx = (q / 2) * 128 + i * sw;
                logic [255:0] s = (q % 2 == 0) ? a : b;
                if (sw == 16) v = longint'($signed(s[idx +: 16]));
                else          v = longint'($signed(s[idx +: 32]));
                if (v > hi) v = hi;
                if (v < lo) v = lo;
                for (int k = 0; k < dw; k++) r[q*64 + i*dw + k] = v[k];
            end
        end
        return r;
    endfunction

    function automatic string tags(input logic [1:0] m, input logic w);
        string s;
        case (m)
            2'b00:   s = "R1 R2";
            2'b01:   s = "R1 R3";
            2'b10:   s = "R1 R4";
            default: s = "R1 R5";
        endcase
        return {s, w ? " R7" : " R6", " R8"};
    endfunction

    task automatic check(input string req, input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic run_op(input logic [255:0] a, input logic [255:0] b,
                          input logic [1:0] m, input logic w);
        logic [255:0] exp;
        @(negedge clk);
        op_a = a; op_b = b; mode = m; wide = w; in_valid = 1'b1;
        exp = model(a, b, m, w);
        @(negedge clk);
        in_valid = 1'b0;
        check({tags(m, w), " valid"}, {255'd0, out_valid}, 256'd1);
        check(tags(m, w), out_res, exp);
        last_exp = exp;
    endtask

    task automatic sweep_op(input int rot, input logic [1:0] m, input logic w);
        logic [255:0] a, b;
        for (int j = 0; j < 16; j++) begin
            a[j*16 +: 16] = edge16[(j + rot) % 16];
            b[j*16 +: 16] = edge16[(j + rot + 5) % 16];
        end
        if (m[1]) begin
            for (int j = 0; j < 8; j++) begin
                a[j*32 +: 32] = edge32[(j + rot) % 16];
                b[j*32 +: 32] = edge32[(j + rot + 9) % 16];
            end
        end
        run_op(a, b, m, w);
    endtask

    initial begin
        #(5.0 * 100000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        edge16 = '{16'h8000, 16'h8001, 16'hFF7F, 16'hFF80, 16'hFF81, 16'hFFFF, 16'h0000, 16'h0001,
                   16'h007E, 16'h007F, 16'h0080, 16'h00FE, 16'h00FF, 16'h0100, 16'h7FFE, 16'h7FFF};
        edge32 = '{32'h80000000, 32'hFFFF7FFF, 32'hFFFF8000, 32'hFFFF8001, 32'hFFFFFFFF,
                   32'h00000000, 32'h00000001, 32'h00007FFE, 32'h00007FFF, 32'h00008000,
                   32'h0000FFFE, 32'h0000FFFF, 32'h00010000, 32'h00010001, 32'h7FFFFFFE,
                   32'h7FFFFFFF};

        // R10: reset state
        repeat (3) @(negedge clk);
        check("R10 valid", {255'd0, out_valid}, 256'd0);
        check("R10 result", out_res, '0);
        rst = 1'b0;

        // boundary sweep across all modes and widths
        for (int m = 0; m < 4; m++)
            for (int w = 0; w < 2; w++)
                for (int r = 0; r < 16; r++)
                    sweep_op(r, 2'(m), 1'(w));

        // R6: upper operand bits must not matter in the 128-bit width
        for (int m = 0; m < 4; m++) begin
            logic [255:0] a = {{4{$urandom}}, {4{32'h00000000}}};
            logic [255:0] b = {{4{$urandom}}, {4{32'h00000000}}};
            run_op(a, b, 2'(m), 1'b0);
            check("R6 upper ignored", out_res, model({128'd0, a[127:0]}, {128'd0, b[127:0]}, 2'(m), 1'b0));
        end

        // random operands
        for (int t = 0; t < 200; t++) begin
            logic [255:0] a, b;
            for (int j = 0; j < 8; j++) begin
                a[j*32 +: 32] = $urandom;
                b[j*32 +: 32] = $urandom;
            end
            run_op(a, b, 2'($urandom), 1'($urandom));
        end

        // R9 / R8: inputs change without in_valid; result holds, valid low
        @(negedge clk);
        op_a = ~op_a; op_b = ~op_b; mode = ~mode; wide = ~wide;
        @(negedge clk);
        check("R8 idle valid", {255'd0, out_valid}, 256'd0);
        check("R9 hold", out_res, last_exp);
        @(negedge clk);
        check("R9 hold second cycle", out_res, last_exp);

        // R10: reset wins over an accepted input
        sweep_op(3, 2'b01, 1'b1);
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b1;
        @(negedge clk);
        check("R10 mid-run valid", {255'd0, out_valid}, 256'd0);
        check("R10 mid-run result", out_res, '0);
        rst = 1'b0; in_valid = 1'b0;
        sweep_op(7, 2'b11, 1'b1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule